// File: doc/BRIEF.md
# Mode-Controlled GPIO Port Register

This block is one eight-pin general-purpose I/O port. A small register bus reaches two registers. The first is a data register with one bit per pin. The second is a mode register that holds a two-bit mode for each pin.

Each pin's mode chooses one of four behaviours:
- The pin is handed to an alternate peripheral, which drives the pad.
- The pin is driven from its data bit.
- The pin is an input with its pull-up requested.
- The pin is an input with its pull-up released.

The block drives the pad controls for each pin: output value, output enable and pull-up enable. It takes in the pad levels and the alternate peripheral's drive signals.

A read of the data register gives a different answer per pin. Pins in a driving mode (alternate or output) return the stored bit. Pins in an input mode return the pad level after a two-stage synchronizer. A write to the data register always stores the value, whatever the mode. The stored value reaches a pad only while that pin is in output mode, so software can load a value before it switches a pin to output.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the data register and the mode register read as zero, so every pin starts in alternate mode.
- R2: A pin whose mode is 00 (alternate) drives pinOut from altOut and pinOe from altOe, with pinPullUp low.
- R3: A pin whose mode is 01 (output) has pinOe high and pinOut equal to its data register bit, with pinPullUp low.
- R4: A pin whose mode is 10 or 11 (input) has pinOe and pinOut low. pinPullUp is high only in mode 10.
- R5: When busAddr is 0, the read of a pin in mode 00 or 01 returns that pin's stored data bit.
- R6: When busAddr is 0, the read of a pin in mode 10 or 11 returns the pinIn level sampled on the rising clock edge two edges before the current edge.
- R7: A write with busAddr 0 stores busWrData[7:0] into the data register in every mode. The new value reaches a pad only when that pin is in output mode.
- R8: Address 1 selects the 16-bit mode register. The mode of pin n sits at bits [2n+1:2n], and a read returns the stored value.
- R9: Read data depends combinationally on busAddr in the same cycle. A data-register read returns zero in bits [15:8]. A write takes effect at the next rising clock edge.
- R10: A write to one address leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Single-cycle write strobe |
| busAddr | input | 1 | Register select: 0 data, 1 mode |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the selected register |
| pinIn | input | 8 | Pad input levels |
| altOut | input | 8 | Alternate peripheral output values |
| altOe | input | 8 | Alternate peripheral output enables |
| pinOut | output | 8 | Pad output values |
| pinOe | output | 8 | Pad output enables |
| pinPullUp | output | 8 | Pad pull-up requests |

## Verification
The hardest case to reach is a data read from a port whose pins are in mixed modes while the pads toggle. In that case some bits must come from the register and others from pad levels two edges old. The stimulus writes random mode words, so each read mixes all four modes across the eight pins. pinIn changes every cycle, so a synchronizer that is one stage short or one stage long would give different values. The stimulus also writes the data register while pins are inputs, and only later switches them to output. That order exposes a write path that is wrongly gated by the mode.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_ALT     = 2'b00,
    MODE_OUT     = 2'b01,
    MODE_IN_PU   = 2'b10,
    MODE_IN_NOPU = 2'b11
  } pinMode_t;

  localparam int MODE_W = 2;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // Strobes from bus decode to the datapath
  typedef struct packed {
    logic dataWr;
    logic ctrlWr;
    logic selCtrl;
  } busStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       busAddr,
  output busStrobe_t strobe
);

  always_comb begin
    strobe.selCtrl = (busAddr == ADDR_CTRL);
    strobe.dataWr  = busWrEn && (busAddr == ADDR_DATA);
    strobe.ctrlWr  = busWrEn && (busAddr == ADDR_CTRL);
  end

  // R10: a write never targets both registers at once
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.dataWr, strobe.ctrlWr}));

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_port_pkg::*;
(
  input  pinMode_t mode,
  input  logic     dataBit,
  input  logic     syncBit,
  input  logic     altOut,
  input  logic     altOe,
  output logic     padOut,
  output logic     padOe,
  output logic     padPullUp,
  output logic     readBit
);

  always_comb begin
    padOut    = 1'b0;
    padOe     = 1'b0;
    padPullUp = 1'b0;
    readBit   = dataBit;
    unique case (mode)
      MODE_ALT: begin
        padOut = altOut;
        padOe  = altOe;
      end
      MODE_OUT: begin
        padOut = dataBit;
        padOe  = 1'b1;
      end
      MODE_IN_PU: begin
        padPullUp = 1'b1;
        readBit   = syncBit;
      end
      MODE_IN_NOPU: begin
        readBit = syncBit;
      end
      default: begin
        readBit = dataBit;
      end
    endcase
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  localparam int BUS_W = PIN_COUNT * MODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic [BUS_W-1:0]     rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinPullUp
);

  localparam int PAD_W = BUS_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] dataReg;
  logic [BUS_W-1:0]     ctrlReg;
  logic [PIN_COUNT-1:0] syncStage1;
  logic [PIN_COUNT-1:0] syncStage2;
  logic [PIN_COUNT-1:0] readBits;
  logic [1:0]           ageCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobe.dataWr) dataReg <= wrData[PIN_COUNT-1:0];
      if (strobe.ctrlWr) ctrlReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= '0;
      syncStage2 <= '0;
    end else begin
      syncStage1 <= pinIn;
      syncStage2 <= syncStage1;
    end
  end

  // Edges since reset, saturating, used only by the checks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ageCnt <= '0;
    else if (ageCnt != 2'd2) ageCnt <= ageCnt + 2'd1;
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    gpio_pin_cell u_cell (
      .mode      (pinMode_t'(ctrlReg[MODE_W*i +: MODE_W])),
      .dataBit   (dataReg[i]),
      .syncBit   (syncStage2[i]),
      .altOut    (altOut[i]),
      .altOe     (altOe[i]),
      .padOut    (pinOut[i]),
      .padOe     (pinOe[i]),
      .padPullUp (pinPullUp[i]),
      .readBit   (readBits[i])
    );

    // R3: output mode drives the stored bit
    assert_out_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlReg[MODE_W*i +: MODE_W] == MODE_OUT) |-> (pinOe[i] && pinOut[i] == dataReg[i]));

    // R4: a pull-up only appears after a mode write
    assert_pullup_source_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pinPullUp[i]) |-> $past(strobe.ctrlWr));

    // R6: input-mode read shows pin level from two edges back
    assert_read_sync_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ageCnt == 2'd2 && !strobe.selCtrl && ctrlReg[MODE_W*i+1])
        |-> (rdData[i] == $past(pinIn[i], 2)));
  end

  always_comb begin
    if (strobe.selCtrl) rdData = ctrlReg;
    else                rdData = {{PAD_W{1'b0}}, readBits};
  end

  // R7: a data write lands whatever the modes are
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> (dataReg == $past(wrData[PIN_COUNT-1:0])));

  // R10: a data write leaves the mode register alone
  assert_ctrl_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> $stable(ctrlReg));

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  localparam int BUS_W = PIN_COUNT * MODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busAddr,
  input  logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic [PIN_COUNT-1:0] altOe,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinPullUp
);

  busStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_port_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .pinIn     (pinIn),
    .altOut    (altOut),
    .altOe     (altOe),
    .rdData    (busRdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinPullUp (pinPullUp)
  );

endmodule

// File: tb/sim_gpio_mode_port.sv
`timescale 1ns/1ps
module sim_gpio_mode_port;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn;
  logic        busAddr;
  logic [15:0] busWrData;
  logic [15:0] busRdData;
  logic [7:0]  pinIn, altOut, altOe;
  logic [7:0]  pinOut, pinOe, pinPullUp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_mode_port u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .altOut(altOut), .altOe(altOe), .pinOut(pinOut), .pinOe(pinOe),
    .pinPullUp(pinPullUp)
  );

  // Reference model state
  logic [7:0]  mData;
  logic [15:0] mCtrl;
  logic [7:0]  pinHist[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mData = 8'h00;
      mCtrl = 16'h0000;
      pinHist.delete();
    end else begin
      pinHist.push_front(pinIn);
      if (pinHist.size() > 3) void'(pinHist.pop_back());
      if (busWrEn) begin
        if (busAddr) mCtrl = busWrData;
        else         mData = busWrData[7:0];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] syncView();
    if (pinHist.size() >= 2) return pinHist[1];
    return 8'h00;
  endfunction

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      logic [7:0] expRd;
      for (int i = 0; i < 8; i++) begin
        int m;
        m = int'(mCtrl[2*i +: 2]);
        case (m)
          0: begin
            check(pinOut[i] === altOut[i] && pinOe[i] === altOe[i] && pinPullUp[i] === 1'b0,
                  "R2", {pinOut[i], pinOe[i], pinPullUp[i]}, {altOut[i], altOe[i], 1'b0});
            expRd[i] = mData[i];
          end
          1: begin
            check(pinOut[i] === mData[i] && pinOe[i] === 1'b1 && pinPullUp[i] === 1'b0,
                  "R3", {pinOut[i], pinOe[i], pinPullUp[i]}, {mData[i], 1'b1, 1'b0});
            expRd[i] = mData[i];
          end
          default: begin
            check(pinOut[i] === 1'b0 && pinOe[i] === 1'b0 && pinPullUp[i] === (m == 2),
                  "R4", {pinOut[i], pinOe[i], pinPullUp[i]}, {1'b0, 1'b0, m == 2});
            expRd[i] = syncView()[i];
          end
        endcase
      end
      if (busAddr)
        check(busRdData === mCtrl, "R8", busRdData, mCtrl);
      else
        check(busRdData === {8'h00, expRd}, "R5 R6 R9", busRdData, {8'h00, expRd});
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic addr, input logic [15:0] d);
    busWrEn = 1'b1; busAddr = addr; busWrData = d;
    cyc();
    busWrEn = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = 1'b0; busWrData = '0;
    pinIn = 8'h00; altOut = 8'h00; altOe = 8'h00;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1: reset values
    busAddr = 1'b0; #1 check(busRdData === 16'h0000, "R1", busRdData, 0);
    busAddr = 1'b1; #1 check(busRdData === 16'h0000, "R1", busRdData, 0);
    altOut = 8'h3C; altOe = 8'hF0; #1
    check(pinOut === 8'h3C && pinOe === 8'hF0, "R1 R2", {pinOut, pinOe}, 16'h3CF0);
    cyc();

    // R7: write while every pin is an input, then switch to output
    wr(1'b1, 16'hFFFF);
    wr(1'b0, 16'h12A5);
    busAddr = 1'b0; pinIn = 8'h00; cyc(); cyc(); cyc();
    check(pinOe === 8'h00 && busRdData === 16'h0000, "R7", {pinOe, busRdData[7:0]}, 0);
    wr(1'b1, 16'h5555);
    busAddr = 1'b0; #1
    check(pinOut === 8'hA5 && pinOe === 8'hFF, "R7", {pinOut, pinOe}, 16'hA5FF);
    check(busRdData === 16'h00A5, "R7 R9", busRdData, 16'h00A5);

    // R10: data write keeps the mode word
    wr(1'b0, 16'hFF00);
    busAddr = 1'b1; #1 check(busRdData === 16'h5555, "R10", busRdData, 16'h5555);
    wr(1'b1, 16'hAAAA);
    busAddr = 1'b0; pinIn = 8'hFF; #1
    check(pinPullUp === 8'hFF, "R4", pinPullUp, 8'hFF);
    cyc(); cyc();
    check(busRdData === 16'h00FF, "R6", busRdData, 16'h00FF);
    busAddr = 1'b1; #1 check(busRdData === 16'hAAAA, "R8 R10", busRdData, 16'hAAAA);
    cyc();

    // Mixed modes with toggling pads
    for (int n = 0; n < 1500; n++) begin
      busWrEn   = ($urandom_range(0, 2) == 0);
      busAddr   = $urandom_range(0, 1);
      busWrData = 16'($urandom);
      pinIn     = 8'($urandom);
      altOut    = 8'($urandom);
      altOe     = 8'($urandom);
      cyc();
    end
    busWrEn = 1'b0;
    cyc();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule